// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to eight maskable interrupt sources, picks the most urgent one and presents it to a processor. It drives a single interrupt request line and a 5-bit vector type. The processor takes the interrupt either with an acknowledge pulse or by reading the poll register. Every source has its own request latch, mask bit, 3-bit priority and trigger-mode select. Priority 0 is the most urgent and priority 7 the least. A global priority ceiling further limits which sources may interrupt.

Taking an interrupt marks its source as in service. While a source is in service, every source of equal or lower urgency is held off, which gives fully nested operation. Software retires a service period by writing the end-of-interrupt register. That write either names a vector type or, with the non-specific flag set, retires the most urgent source in service. A poll-status read shows the same winner as the poll register but acknowledges nothing.

Register map (4-bit address, 16-bit data):
- 0..7 — source control. Bits [2:0] hold the priority, bit 3 the mask and bit 4 the trigger mode (1 = level).
- 8 — mask vector, one bit per source.
- 9 — priority ceiling, in bits [2:0].
- 10 — in-service vector (read only).
- 11 — request vector (read only).
- 12 — poll.
- 13 — poll status.
- 14 — end-of-interrupt (write).

The vector type of source i is 8 + i.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source control register reads 0x000F (masked, priority 7, edge mode). The mask vector reads 0x00FF, the priority ceiling reads 7 and the in-service vector reads 0. `int_req` is 0 and poll status reads 0.
- R2: In edge mode a Low-to-High input transition latches a request that persists after the input falls. In level mode the request follows the active-High input and disappears when the input falls. A request becomes visible one clock after the input changes.
- R3: Among eligible requests, the one with the numerically lowest priority wins, and on a tie the lower source index wins. `int_type` = 8 + winning index while `int_req` is 1.
- R4: A set mask bit blocks its source. The per-source mask bit (control bit 3) and the mask vector (address 8) are one storage, so a write through either is seen through the other.
- R5: A source whose priority is numerically greater than the priority ceiling is blocked.
- R6: `int_req` is 1 only when the winner's priority is strictly lower in value than the priority of every source in service.
- R7: While `int_req` is 1, an `int_ack` pulse sets the winner's in-service bit and clears its edge request latch. The request vector then no longer shows that source.
- R8: A poll read (address 12) returns bit 15 = pending flag and bits [4:0] = winner type (0 when nothing is pending), and it acknowledges like R7. A poll-status read (address 13) returns the same word with no change to in-service state.
- R9: An end-of-interrupt write with bit 15 = 0 clears the in-service bit of the source whose type is in bits [4:0]. A type outside 8..15 has no effect.
- R10: An end-of-interrupt write with bit 15 = 1 clears the in-service bit of the most urgent source in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt source inputs |
| int_ack | input | 1 | Interrupt acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| int_type | output | 5 | Vector type of the winning source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (poll side effect) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |

## Verification
A corrupted in-service bit shows on the next clock: `int_req` either stays low while an eligible request waits, or rises for a source that should be held off. A stale edge latch makes the request vector and the poll word report a source again right after it has been taken. A mis-resolved priority shows at once as a wrong `int_type`. The sweeps over every source, priority and ceiling value, and over every pair of sources, catch such faults within a few cycles of the stimulus that exposes them.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] A_MASK  = 4'd8;
  localparam logic [ADDR_W-1:0] A_PCEIL = 4'd9;
  localparam logic [ADDR_W-1:0] A_INSV  = 4'd10;
  localparam logic [ADDR_W-1:0] A_REQ   = 4'd11;
  localparam logic [ADDR_W-1:0] A_POLL  = 4'd12;
  localparam logic [ADDR_W-1:0] A_PSTAT = 4'd13;
  localparam logic [ADDR_W-1:0] A_EOI   = 4'd14;
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic level_mode,
  input  logic take,
  output logic req
);
  logic irq_q, irq_d;
  logic edge_q, edge_d;

  always_comb begin
    irq_d  = irq_in;
    edge_d = edge_q;
    if (level_mode)              edge_d = 1'b0;
    else if (irq_in && !irq_q)   edge_d = 1'b1;
    else if (take)               edge_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      edge_q <= edge_d;
    end
  end

  assign req = level_mode ? irq_q : edge_q;
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vec,
  input  logic [N-1:0][PW-1:0] pri,
  output logic                 found,
  output logic [IW-1:0]        idx,
  output logic [PW-1:0]        best
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (vec[i] && (!found || pri[i] < best)) begin
        found = 1'b1;
        best  = pri[i];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int PRI_W     = 3,
  parameter int TYPE_W    = 5,
  parameter int TYPE_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              int_ack,
  output logic              int_req,
  output logic [TYPE_W-1:0] int_type,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [TYPE_W-1:0] BASE_V = TYPE_W'(TYPE_BASE);
  localparam logic [TYPE_W-1:0] NSRC_V = TYPE_W'(N_SRC);

  logic [N_SRC-1:0][PRI_W-1:0] pri_q, pri_d;
  logic [N_SRC-1:0]            mask_q, mask_d, lvl_q, lvl_d, isr_q, isr_d;
  logic [PRI_W-1:0]            pceil_q, pceil_d;

  logic [N_SRC-1:0] req, elig, take_vec, eoi_clr;
  logic             win_found, isr_found, pending, take, eoi_wr;
  logic [IDX_W-1:0] win_idx, isr_idx;
  logic [PRI_W-1:0] win_pri, isr_pri;
  logic [TYPE_W-1:0] eoi_type, eoi_off;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-2:TYPE_W];

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      pic_req_latch u_lat (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in[g]),
        .level_mode(lvl_q[g]), .take(take_vec[g]), .req(req[g])
      );
      assign elig[g] = req[g] && !mask_q[g] && (pri_q[g] <= pceil_q);
    end
  endgenerate

  pic_resolver #(.N(N_SRC), .PW(PRI_W)) u_win (
    .vec(elig), .pri(pri_q), .found(win_found), .idx(win_idx), .best(win_pri)
  );
  pic_resolver #(.N(N_SRC), .PW(PRI_W)) u_isr (
    .vec(isr_q), .pri(pri_q), .found(isr_found), .idx(isr_idx), .best(isr_pri)
  );

  assign pending  = win_found && (!isr_found || (win_pri < isr_pri));
  assign int_req  = pending;
  assign int_type = pending ? (BASE_V + TYPE_W'(win_idx)) : '0;
  assign take     = pending && (int_ack || (reg_rd && reg_addr == A_POLL));
  assign take_vec = take ? (N_SRC'(1) << win_idx) : '0;
  assign eoi_wr   = reg_wr && (reg_addr == A_EOI);
  assign eoi_type = reg_wdata[TYPE_W-1:0];
  assign eoi_off  = eoi_type - BASE_V;

  always_comb begin
    eoi_clr = '0;
    if (eoi_wr) begin
      if (reg_wdata[DATA_W-1]) begin
        if (isr_found) eoi_clr = N_SRC'(1) << isr_idx;
      end else if (eoi_type >= BASE_V && eoi_off < NSRC_V) begin
        eoi_clr = N_SRC'(1) << eoi_off[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    pri_d   = pri_q;
    mask_d  = mask_q;
    lvl_d   = lvl_q;
    pceil_d = pceil_q;
    isr_d   = (isr_q & ~eoi_clr) | take_vec;
    if (reg_wr) begin
      if (reg_addr < ADDR_W'(N_SRC)) begin
        pri_d[reg_addr[IDX_W-1:0]]  = reg_wdata[PRI_W-1:0];
        mask_d[reg_addr[IDX_W-1:0]] = reg_wdata[PRI_W];
        lvl_d[reg_addr[IDX_W-1:0]]  = reg_wdata[PRI_W+1];
      end else if (reg_addr == A_MASK) begin
        mask_d = reg_wdata[N_SRC-1:0];
      end else if (reg_addr == A_PCEIL) begin
        pceil_d = reg_wdata[PRI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q   <= '1;
      mask_q  <= '1;
      lvl_q   <= '0;
      pceil_q <= '1;
      isr_q   <= '0;
    end else begin
      pri_q   <= pri_d;
      mask_q  <= mask_d;
      lvl_q   <= lvl_d;
      pceil_q <= pceil_d;
      isr_q   <= isr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(N_SRC)) begin
      reg_rdata[PRI_W-1:0] = pri_q[reg_addr[IDX_W-1:0]];
      reg_rdata[PRI_W]     = mask_q[reg_addr[IDX_W-1:0]];
      reg_rdata[PRI_W+1]   = lvl_q[reg_addr[IDX_W-1:0]];
    end else begin
      case (reg_addr)
        A_MASK:  reg_rdata[N_SRC-1:0] = mask_q;
        A_PCEIL: reg_rdata[PRI_W-1:0] = pceil_q;
        A_INSV:  reg_rdata[N_SRC-1:0] = isr_q;
        A_REQ:   reg_rdata[N_SRC-1:0] = req;
        A_POLL, A_PSTAT: begin
          reg_rdata[DATA_W-1]   = pending;
          reg_rdata[TYPE_W-1:0] = int_type;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  // R6
  winner_not_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> !isr_q[win_idx]);

  // R3
  grant_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (req[win_idx] && !mask_q[win_idx] && pri_q[win_idx] <= pceil_q));

  // R7
  ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack && !eoi_wr) |=> isr_q[$past(win_idx)]);

  // R8
  status_read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_PSTAT && !int_ack && !reg_wr) |=> (isr_q == $past(isr_q)));

  // R10
  nonspec_eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && reg_wdata[DATA_W-1] && isr_q != '0 && !take)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R7
  single_service_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  irq;
  logic        int_ack, int_req, reg_wr, reg_rd;
  logic [4:0]  int_type;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, rv;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .int_ack(int_ack),
    .int_req(int_req), .int_type(int_type), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; int_ack = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 int_req", {15'b0, int_req}, 16'h0);
    rd(4'd0, rv);  chk("R1 ctl0", rv, 16'h000F);
    rd(4'd7, rv);  chk("R1 ctl7", rv, 16'h000F);
    rd(4'd8, rv);  chk("R1 mask", rv, 16'h00FF);
    rd(4'd9, rv);  chk("R1 ceiling", rv, 16'h0007);
    rd(4'd10, rv); chk("R1 insv", rv, 16'h0000);
    rd(4'd13, rv); chk("R1 pstat", rv, 16'h0000);

    // R5 sweep: source x priority x ceiling, level mode
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 8; p++)
        for (int pm = 0; pm < 8; pm++) begin
          wr(4'(s), 16'h0010 | 16'(p));
          wr(4'd9, 16'(pm));
          set_irq(8'(1 << s));
          chk("R5 req", {15'b0, int_req}, (p <= pm) ? 16'h1 : 16'h0);
          if (p <= pm) chk("R3 type", {11'b0, int_type}, 16'(8 + s));
          set_irq(8'h00);
          wr(4'(s), 16'h000F);
        end

    // R3 pair sweep with ties
    wr(4'd9, 16'h7);
    for (int i = 0; i < 8; i++)
      for (int j = i + 1; j < 8; j++) begin
        int pi, pj, w;
        pi = (i * 5 + j) % 8;
        pj = (j * 3 + i) % 8;
        w  = (pj < pi) ? j : i;
        wr(4'(i), 16'h0010 | 16'(pi));
        wr(4'(j), 16'h0010 | 16'(pj));
        set_irq(8'((1 << i) | (1 << j)));
        chk("R3 pair", {10'b0, int_req, int_type}, 16'h20 | 16'(8 + w));
        set_irq(8'h00);
        wr(4'(i), 16'h000F);
        wr(4'(j), 16'h000F);
      end

    // R4 shared mask storage
    do_reset();
    wr(4'd8, 16'h00FB);
    rd(4'd2, rv); chk("R4 ctl2 via vec", rv, 16'h0007);
    wr(4'd2, 16'h0013);
    set_irq(8'h04);
    chk("R4 unmasked", {10'b0, int_req, int_type}, 16'h20 | 16'd10);
    wr(4'd2, 16'h001B);
    rd(4'd8, rv); chk("R4 vec via ctl", rv, 16'h00FF);
    chk("R4 masked", {15'b0, int_req}, 16'h0);
    set_irq(8'h00);

    // R2 edge vs level
    do_reset();
    wr(4'd3, 16'h0012);
    set_irq(8'h08);
    chk("R2 level on", {10'b0, int_req, int_type}, 16'h20 | 16'd11);
    set_irq(8'h00);
    chk("R2 level off", {15'b0, int_req}, 16'h0);
    wr(4'd1, 16'h0002);
    set_irq(8'h02);
    set_irq(8'h00);
    chk("R2 edge held", {10'b0, int_req, int_type}, 16'h20 | 16'd9);
    rd(4'd11, rv); chk("R2 req vec", rv, 16'h0002);

    // R6 R7 R9 R10 nesting and EOI
    do_reset();
    wr(4'd0, 16'h0004);
    wr(4'd1, 16'h0004);
    wr(4'd2, 16'h0001);
    set_irq(8'h01); set_irq(8'h00);
    chk("R7 pre", {10'b0, int_req, int_type}, 16'h20 | 16'd8);
    ack();
    rd(4'd10, rv); chk("R7 insv", rv, 16'h0001);
    chk("R7 drop", {15'b0, int_req}, 16'h0);
    set_irq(8'h02); set_irq(8'h00);
    chk("R6 equal blocked", {15'b0, int_req}, 16'h0);
    rd(4'd11, rv); chk("R7 latch cleared", rv, 16'h0002);
    set_irq(8'h04); set_irq(8'h00);
    chk("R6 nest", {10'b0, int_req, int_type}, 16'h20 | 16'd10);
    ack();
    rd(4'd10, rv); chk("R7 insv2", rv, 16'h0005);
    wr(4'd14, 16'h8000);
    rd(4'd10, rv); chk("R10 nonspec", rv, 16'h0001);
    chk("R6 still blocked", {15'b0, int_req}, 16'h0);
    wr(4'd14, 16'h0008);
    rd(4'd10, rv); chk("R9 specific", rv, 16'h0000);
    chk("R9 release", {10'b0, int_req, int_type}, 16'h20 | 16'd9);
    ack();
    wr(4'd14, 16'h0010);
    rd(4'd10, rv); chk("R9 above range", rv, 16'h0002);
    wr(4'd14, 16'h0007);
    rd(4'd10, rv); chk("R9 below range", rv, 16'h0002);

    // R8 poll and poll status
    do_reset();
    wr(4'd4, 16'h0000);
    set_irq(8'h10); set_irq(8'h00);
    rd(4'd13, rv); chk("R8 pstat", rv, 16'h800C);
    rd(4'd10, rv); chk("R8 pstat no ack", rv, 16'h0000);
    chk("R8 still req", {15'b0, int_req}, 16'h1);
    rd(4'd12, rv); chk("R8 poll", rv, 16'h800C);
    rd(4'd10, rv); chk("R8 poll acked", rv, 16'h0010);
    rd(4'd12, rv); chk("R8 poll empty", rv, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule